// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Mapper

This block sits between a CPU, a video unit and the memories of a cartridge-style board. It turns their narrow addresses into wide banked addresses. The CPU sets the mapping through a one-bit serial port. Each register write carries one data bit. After five bits are gathered, the block loads a 5-bit control register. The CPU address bits in force on that fifth write pick which register is loaded. A write with its clear flag set drops any partial sequence and puts program banking back into its 16K "fixed upper bank" arrangement.

The block translates addresses in three ways, all combinationally from the stored configuration:

- Program addresses map in 32K or 16K units, with one 16K half that can be fixed.
- Character addresses map as one 8K bank or as two independent 4K banks.
- Nametable addresses are folded into a 2K space by one of four mirroring schemes.

A RAM-disable flag is also driven out. After every accepted write there is a short lockout, so a CPU that writes the same location on back-to-back cycles only has its first write counted.

Top module: `serial_bank_mapper`

## Requirements
- R1: An accepted write with `wr_clr_i`=0 shifts `wr_bit_i` into bit 4 of a 5-bit shift value, and the older bits move down one place. On the fifth such write, the assembled value is committed to register `wr_addr_i[1:0]` (CPU address bits 14:13), and the count restarts. The registers are:
  - Register 0: bit 4 is the character mode, bit 3 is the program size, bit 2 is the program mode, and bits 1:0 are the mirroring.
  - Register 1: character bank A.
  - Register 2: character bank B.
  - Register 3: bit 4 is RAM disable, and bits 3:0 are the program bank.
- R2: An accepted write with `wr_clr_i`=1 zeroes the bit count and sets both program size and program mode to 1. It changes no other register.
- R3: After an accepted write, any write in the next two clock cycles is ignored.
- R4: A write with `wr_addr_i[2]`=0 (CPU address bit 15 clear) is ignored and does not start a lockout.
- R5: With program size 0 (32K), the program bank is `{prg_bank[3:1], prg_addr_i[14]}`, and `prg_addr_o` = bank·2^14 + `prg_addr_i[13:0]`.
- R6: With program size 1 (16K), the half whose `prg_addr_i[14]` differs from program mode uses the program bank. The other half uses bank 0 (lower half) or bank 15 (upper half).
- R7: With character mode 0, the character bank is bank A with bit 0 replaced by `chr_addr_i[12]`. `chr_addr_o` = bank·2^12 + `chr_addr_i[11:0]`.
- R8: With character mode 1, `chr_addr_i[12]` selects bank A (0) or bank B (1).
- R9: The mirroring value sets `nt_addr_o[10]` as follows: 0 gives 0, 1 gives 1, 2 gives `nt_addr_i[10]`, and 3 gives `nt_addr_i[11]`. `nt_addr_o[9:0]` always equals `nt_addr_i[9:0]`.
- R10: During reset, the following are held:
  - Character mode, mirroring, bank A, RAM disable, program bank, shift state and lockout are 0.
  - Program size and program mode are 1.
  - Bank B is 1.
- R11: `ram_dis_o` equals the RAM disable bit of register 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | 3 | CPU address bits 15:13 of the write |
| wr_clr_i | input | 1 | CPU data bit 7: restart the serial sequence |
| wr_bit_i | input | 1 | CPU data bit 0: the serial data bit |
| prg_addr_i | input | 15 | Program-space address |
| chr_addr_i | input | 13 | Character-space address |
| nt_addr_i | input | 12 | Nametable address |
| prg_addr_o | output | 18 | Banked program address |
| chr_addr_o | output | 17 | Banked character address |
| nt_addr_o | output | 11 | Mirrored nametable address |
| ram_dis_o | output | 1 | RAM disable flag |

## Verification
Two functions can fall in the same cycle:

- A register commit and a translation that depends on the register being written.
- A new write and a running lockout window.

The bench drives fresh translation addresses on every cycle, including the cycle of each fifth write. It also issues bursts of writes on consecutive cycles, so that most of them land inside a lockout. A behavioural model decides, cycle by cycle, which writes count and what each output must be. The outputs are compared against it on every clock.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int REG_W      = 5;
  localparam int PRG_BANK_W = 4;
  localparam int CHR_BANK_W = 5;
  localparam int PRG_OFS_W  = 14;
  localparam int CHR_OFS_W  = 12;
  localparam int NT_OFS_W   = 10;
  localparam int LOCK_CYC   = 2;

  typedef enum logic [1:0] {
    MIR_LOW  = 2'd0,
    MIR_HIGH = 2'd1,
    MIR_VERT = 2'd2,
    MIR_HORZ = 2'd3
  } mirror_e;

  typedef struct packed {
    logic                  chr_mode;
    logic                  prg_size;
    logic                  prg_mode;
    mirror_e               mirror;
    logic [CHR_BANK_W-1:0] chr_bank_a;
    logic [CHR_BANK_W-1:0] chr_bank_b;
    logic                  ram_dis;
    logic [PRG_BANK_W-1:0] prg_bank;
  } cfg_t;
endpackage

// File: rtl/sbm_serial_port.sv
module sbm_serial_port
  import sbm_pkg::*;
#(
  parameter int LOCK = LOCK_CYC,
  parameter int W    = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [2:0]   wr_addr_i,
  input  logic         wr_clr_i,
  input  logic         wr_bit_i,
  output logic         accept_o,
  output logic         abort_o,
  output logic         commit_o,
  output logic [1:0]   sel_o,
  output logic [W-1:0] value_o
);
  localparam int LW = $clog2(LOCK + 1);
  localparam int CW = $clog2(W);

  logic [LW-1:0] lock_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  shift_q;
  logic [W-1:0]  shifted;
  logic          shift_en;

  assign accept_o = wr_i && wr_addr_i[2] && (lock_q == '0);
  assign abort_o  = accept_o && wr_clr_i;
  assign shift_en = accept_o && !wr_clr_i;
  assign shifted  = {wr_bit_i, shift_q[W-1:1]};
  assign commit_o = shift_en && (cnt_q == CW'(W - 1));
  assign sel_o    = wr_addr_i[1:0];
  assign value_o  = shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= '0;
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      if (accept_o)             lock_q <= LW'(LOCK);
      else if (lock_q != '0)    lock_q <= lock_q - 1'b1;
      if (abort_o)              cnt_q <= '0;
      else if (shift_en)        cnt_q <= commit_o ? '0 : cnt_q + 1'b1;
      // partial data is kept on abort; five fresh shifts replace it fully
      if (shift_en)             shift_q <= shifted;
    end
  end
endmodule

// File: rtl/sbm_cfg_regs.sv
module sbm_cfg_regs
  import sbm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             commit_i,
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] value_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q            <= '0;
      cfg_q.prg_size   <= 1'b1;
      cfg_q.prg_mode   <= 1'b1;
      cfg_q.chr_bank_b <= CHR_BANK_W'(1);
    end else if (abort_i) begin
      cfg_q.prg_size <= 1'b1;
      cfg_q.prg_mode <= 1'b1;
    end else if (commit_i) begin
      case (sel_i)
        2'd0: begin
          cfg_q.chr_mode <= value_i[4];
          cfg_q.prg_size <= value_i[3];
          cfg_q.prg_mode <= value_i[2];
          cfg_q.mirror   <= mirror_e'(value_i[1:0]);
        end
        2'd1: cfg_q.chr_bank_a <= value_i[CHR_BANK_W-1:0];
        2'd2: cfg_q.chr_bank_b <= value_i[CHR_BANK_W-1:0];
        default: begin
          cfg_q.ram_dis  <= value_i[4];
          cfg_q.prg_bank <= value_i[PRG_BANK_W-1:0];
        end
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sbm_prg_xlate.sv
module sbm_prg_xlate #(
  parameter int OFS_W  = 14,
  parameter int BANK_W = 4
) (
  input  logic [BANK_W-1:0]       bank_i,
  input  logic                    size16_i,
  input  logic                    mode_i,
  input  logic [OFS_W:0]          addr_i,
  output logic [BANK_W+OFS_W-1:0] addr_o
);
  logic              hi;
  logic [BANK_W-1:0] bank;

  assign hi = addr_i[OFS_W];

  always_comb begin
    if (!size16_i)         bank = {bank_i[BANK_W-1:1], hi};
    else if (hi != mode_i) bank = bank_i;
    else                   bank = {BANK_W{hi}};
  end

  assign addr_o = {bank, addr_i[OFS_W-1:0]};
endmodule

// File: rtl/sbm_chr_xlate.sv
module sbm_chr_xlate #(
  parameter int OFS_W  = 12,
  parameter int BANK_W = 5
) (
  input  logic [BANK_W-1:0]       bank_a_i,
  input  logic [BANK_W-1:0]       bank_b_i,
  input  logic                    split_i,
  input  logic [OFS_W:0]          addr_i,
  output logic [BANK_W+OFS_W-1:0] addr_o
);
  logic              hi;
  logic [BANK_W-1:0] bank;

  assign hi = addr_i[OFS_W];

  always_comb begin
    if (split_i) bank = hi ? bank_b_i : bank_a_i;
    else         bank = {bank_a_i[BANK_W-1:1], hi};
  end

  assign addr_o = {bank, addr_i[OFS_W-1:0]};
endmodule

// File: rtl/sbm_nt_xlate.sv
module sbm_nt_xlate
  import sbm_pkg::*;
#(
  parameter int OFS_W = NT_OFS_W
) (
  input  mirror_e          mirror_i,
  input  logic [OFS_W+1:0] addr_i,
  output logic [OFS_W:0]   addr_o
);
  logic page;

  always_comb begin
    case (mirror_i)
      MIR_LOW:  page = 1'b0;
      MIR_HIGH: page = 1'b1;
      MIR_VERT: page = addr_i[OFS_W];
      default:  page = addr_i[OFS_W+1];
    endcase
  end

  assign addr_o = {page, addr_i[OFS_W-1:0]};
endmodule

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper
  import sbm_pkg::*;
#(
  parameter int PRG_IW = PRG_OFS_W + 1,
  parameter int PRG_OW = PRG_OFS_W + PRG_BANK_W,
  parameter int CHR_IW = CHR_OFS_W + 1,
  parameter int CHR_OW = CHR_OFS_W + CHR_BANK_W,
  parameter int NT_IW  = NT_OFS_W + 2,
  parameter int NT_OW  = NT_OFS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        wr_addr_i,
  input  logic              wr_clr_i,
  input  logic              wr_bit_i,
  input  logic [PRG_IW-1:0] prg_addr_i,
  input  logic [CHR_IW-1:0] chr_addr_i,
  input  logic [NT_IW-1:0]  nt_addr_i,
  output logic [PRG_OW-1:0] prg_addr_o,
  output logic [CHR_OW-1:0] chr_addr_o,
  output logic [NT_OW-1:0]  nt_addr_o,
  output logic              ram_dis_o
);
  logic             accept;
  logic             abort;
  logic             commit;
  logic [1:0]       sel;
  logic [REG_W-1:0] value;
  cfg_t             cfg;

  sbm_serial_port #(.LOCK(LOCK_CYC), .W(REG_W)) u_port (
    .clk_i, .rst_ni, .wr_i, .wr_addr_i, .wr_clr_i, .wr_bit_i,
    .accept_o(accept), .abort_o(abort), .commit_o(commit),
    .sel_o(sel), .value_o(value)
  );

  sbm_cfg_regs u_regs (
    .clk_i, .rst_ni, .abort_i(abort), .commit_i(commit),
    .sel_i(sel), .value_i(value), .cfg_o(cfg)
  );

  sbm_prg_xlate #(.OFS_W(PRG_OFS_W), .BANK_W(PRG_BANK_W)) u_prg (
    .bank_i(cfg.prg_bank), .size16_i(cfg.prg_size), .mode_i(cfg.prg_mode),
    .addr_i(prg_addr_i), .addr_o(prg_addr_o)
  );

  sbm_chr_xlate #(.OFS_W(CHR_OFS_W), .BANK_W(CHR_BANK_W)) u_chr (
    .bank_a_i(cfg.chr_bank_a), .bank_b_i(cfg.chr_bank_b), .split_i(cfg.chr_mode),
    .addr_i(chr_addr_i), .addr_o(chr_addr_o)
  );

  sbm_nt_xlate #(.OFS_W(NT_OFS_W)) u_nt (
    .mirror_i(cfg.mirror), .addr_i(nt_addr_i), .addr_o(nt_addr_o)
  );

  assign ram_dis_o = cfg.ram_dis;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker
  import sbm_pkg::*;
(
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              accept_i,
  input logic                              abort_i,
  input cfg_t                              cfg_i,
  input logic [PRG_OFS_W:0]                prg_addr_i,
  input logic [PRG_OFS_W+PRG_BANK_W-1:0]   prg_addr_o,
  input logic [CHR_OFS_W:0]                chr_addr_i,
  input logic [CHR_OFS_W+CHR_BANK_W-1:0]   chr_addr_o,
  input logic [NT_OFS_W+1:0]               nt_addr_i,
  input logic [NT_OFS_W:0]                 nt_addr_o
);
  logic acc_d1, acc_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_d1 <= 1'b0;
      acc_d2 <= 1'b0;
    end else begin
      acc_d1 <= accept_i;
      acc_d2 <= acc_d1;
    end
  end

  a_r3_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_d1 || acc_d2) |-> !accept_i);

  a_r2_abort_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (cfg_i.prg_size && cfg_i.prg_mode));

  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(cfg_i));

  a_r5_prg_32k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.prg_size |-> (prg_addr_o[PRG_OFS_W:0] == prg_addr_i));

  a_r6_prg_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.prg_size && (prg_addr_i[PRG_OFS_W] == cfg_i.prg_mode)) |->
      (prg_addr_o[PRG_OFS_W+PRG_BANK_W-1:PRG_OFS_W] == {PRG_BANK_W{prg_addr_i[PRG_OFS_W]}}));

  a_r7_chr_8k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.chr_mode |-> (chr_addr_o[CHR_OFS_W:0] == chr_addr_i));

  a_r9_nt_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nt_addr_o[NT_OFS_W-1:0] == nt_addr_i[NT_OFS_W-1:0]);
endmodule

bind serial_bank_mapper sbm_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .abort_i(abort), .cfg_i(cfg),
  .prg_addr_i(prg_addr_i), .prg_addr_o(prg_addr_o),
  .chr_addr_i(chr_addr_i), .chr_addr_o(chr_addr_o),
  .nt_addr_i(nt_addr_i), .nt_addr_o(nt_addr_o)
);

// File: tb/serial_bank_mapper_tb.sv
`timescale 1ns/1ps
module serial_bank_mapper_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic        wr_clr_i = 1'b0;
  logic        wr_bit_i = 1'b0;
  logic [14:0] prg_addr_i = '0;
  logic [12:0] chr_addr_i = '0;
  logic [11:0] nt_addr_i = '0;
  logic [17:0] prg_addr_o;
  logic [16:0] chr_addr_o;
  logic [10:0] nt_addr_o;
  logic        ram_dis_o;

  int compared = 0, mismatched = 0;
  string phase = "R10 reset";
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  serial_bank_mapper u_dut (.*);

  // behavioural reference
  int m_lock, m_cnt, m_shift, m_chr_mode, m_size, m_mode, m_mirror;
  int m_bank_a, m_bank_b, m_ram_dis, m_prg_bank, nv;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lock = 0; m_cnt = 0; m_shift = 0; m_chr_mode = 0; m_size = 1; m_mode = 1;
      m_mirror = 0; m_bank_a = 0; m_bank_b = 1; m_ram_dis = 0; m_prg_bank = 0;
    end else if (wr_i && wr_addr_i[2] && m_lock == 0) begin
      m_lock = 2;
      if (wr_clr_i) begin
        m_cnt = 0; m_size = 1; m_mode = 1;
      end else begin
        nv = (int'(wr_bit_i) << 4) | (m_shift >> 1);
        m_shift = nv;
        m_cnt++;
        if (m_cnt == 5) begin
          m_cnt = 0;
          case (int'(wr_addr_i[1:0]))
            0: begin m_chr_mode = (nv >> 4) & 1; m_size = (nv >> 3) & 1;
                     m_mode = (nv >> 2) & 1; m_mirror = nv & 3; end
            1: m_bank_a = nv;
            2: m_bank_b = nv;
            default: begin m_ram_dis = (nv >> 4) & 1; m_prg_bank = nv & 15; end
          endcase
        end
      end
    end else if (m_lock > 0) m_lock--;
  end

  function automatic int exp_prg(int a);
    int region = (a >> 14) & 1;
    int bank = (m_prg_bank & ~1) + region;
    if (m_size != 0) begin
      bank = region ? 15 : 0;
      if (region != m_mode) bank = m_prg_bank;
    end
    return bank * 16384 + (a & 16383);
  endfunction

  function automatic int exp_chr(int a);
    int region = (a >> 12) & 1;
    int bank = region ? m_bank_b : m_bank_a;
    if (m_chr_mode == 0) bank = (m_bank_a & ~1) | region;
    return bank * 4096 + (a & 4095);
  endfunction

  function automatic int exp_nt(int a);
    case (m_mirror)
      0: return a & 1023;
      1: return 1024 | (a & 1023);
      2: return (a & 1024) | (a & 1023);
      default: return ((a & 2048) >> 1) | (a & 1023);
    endcase
  endfunction

  task automatic cmp(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=0x%0h expected=0x%0h", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk_i) if (!done) begin
    cmp(m_size ? "R6 prg 16K" : "R5 prg 32K", int'(prg_addr_o), exp_prg(int'(prg_addr_i)));
    cmp(m_chr_mode ? "R8 chr 4K" : "R7 chr 8K", int'(chr_addr_o), exp_chr(int'(chr_addr_i)));
    cmp("R9 mirroring", int'(nt_addr_o), exp_nt(int'(nt_addr_i)));
    cmp("R11 ram disable", int'(ram_dis_o), m_ram_dis);
  end

  task automatic step(bit wr, bit [2:0] a, bit clr, bit b);
    @(posedge clk_i); #1;
    wr_i = wr; wr_addr_i = a; wr_clr_i = clr; wr_bit_i = b;
    prg_addr_i = 15'($urandom); chr_addr_i = 13'($urandom); nt_addr_i = 12'($urandom);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 3'($urandom), 0, 0);
  endtask

  // R1: five spaced writes; only the fifth address chooses the register
  task automatic load(int sel, int val);
    for (int i = 0; i < 5; i++) begin
      step(1, (i == 4) ? {1'b1, 2'(sel)} : {1'b1, 2'($urandom)}, 0, 1'((val >> i) & 1));
      idle(2);
    end
  endtask

  initial begin
    idle(4);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    idle(4);
    phase = "R1 load sweep";
    for (int v = 0; v < 32; v++) begin
      load(0, v);
      load(1, int'($urandom) & 31);
      load(2, int'($urandom) & 31);
      load(3, int'($urandom) & 31);
      idle(12);
    end
    phase = "R2 abort mid-sequence";
    load(0, 5'b00011);
    for (int i = 0; i < 3; i++) begin step(1, 3'b111, 0, 1); idle(2); end
    step(1, 3'b100, 1, 0); idle(2);
    idle(6);
    load(3, 5'b10110);
    idle(6);
    phase = "R3 back-to-back bursts";
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 11; i++) step(1, {1'b1, 2'($urandom)}, 0, 1'($urandom));
      idle(5);
    end
    phase = "R4 low-half writes";
    for (int k = 0; k < 60; k++) begin
      step(1, {1'b0, 2'($urandom)}, 1'($urandom), 1'($urandom));
      step(1, {1'b1, 2'($urandom)}, 0, 1'($urandom));
      idle(int'($urandom) % 3);
    end
    phase = "R1 R2 R3 R4 mixed";
    for (int k = 0; k < 4000; k++)
      step(1'(($urandom % 3) == 0), 3'($urandom), 1'(($urandom % 12) == 0), 1'($urandom));
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog [%s] actual=running expected=finished", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule